// File: doc/BRIEF.md
# Strobe-Qualified Register Bus Slave

This block sits on a simple parallel register bus and answers for a window of eight 8-bit registers. A bus master raises an enable strobe with an address, a write qualifier and, for writes, a data byte. The slave decodes the byte address against a base address and a register stride, flags that it is selected, returns the addressed register's content on a 16-bit read lane, and acknowledges the access one clock later.

The register action itself happens only when the strobe is dropped. On the first clock after the strobe goes low, a write stores the byte into the register, and either kind of access raises a one-clock action pulse with the register index. Logic behind the registers uses the read pulse to pop a queue or clear a flag. The address, data and index used by the action are captured while the strobe is high. A master may therefore move the address bus as soon as it lowers the strobe. The selected flag lets an external multiplexer merge the read lanes of several slaves.

Top module: `strobe_reg_slave`

## Requirements
- R1: `bus_sel` is high exactly when `bus_en` is high and the byte address `{bus_addr, ADDR_LO zero bits}` lies in the window. Membership requires that the offset `byte_addr - BASE_ADDR` is below `8*STRIDE` and is a multiple of `STRIDE`.
- R2: The register index is `offset / STRIDE`. An access outside the window leaves `bus_sel` and `bus_ack` low, returns zero read data, changes no register and raises no action pulse.
- R3: `bus_ack` rises one clock after a sampled strobe with a matching address. It stays high while the strobe stays high, and it is low from the first clock at which the strobe is sampled low.
- R4: While selected, `bus_rdata[7:0]` holds the addressed register and `bus_rdata[15:8]` is zero. While not selected, `bus_rdata` is all zero.
- R5: At the first clock at which a selected strobe is sampled low after being high, a write (`bus_wr`=1 at that clock) loads the data byte into the register. Both the byte and the index are the values captured while the strobe was high.
- R6: That same clock raises `act_wr` (write) or `act_rd` (read) for exactly one cycle, with `act_idx` equal to the register index. The two pulses are never high together.
- R7: Asynchronous active-high `rst` clears all eight registers to zero and holds `bus_ack`, `act_wr` and `act_rd` low.
- R8: A read access leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_addr | input | ADDR_HI-ADDR_LO+1 | Address bits ADDR_HI down to ADDR_LO |
| bus_wdata | input | 8 | Write data byte, valid while the strobe is high |
| bus_en | input | 1 | Access strobe, synchronous to clk |
| bus_wr | input | 1 | Write qualifier, stable until two clocks after the strobe drops |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdata | output | 16 | Read data, register in the low byte |
| bus_sel | output | 1 | Strobe high and address inside the window |
| act_wr | output | 1 | One-clock write action pulse |
| act_rd | output | 1 | One-clock read action pulse |
| act_idx | output | 3 | Register index of the current action |

## Verification
Two functions meet in the clock after the strobe drops. The register update and its action pulse fire, while the bus has already moved to a new address and an inverted data byte. The bench provokes this on every access by scrambling address and data in the same cycle that it lowers the strobe. It judges the result by sweeping every address and reading each register back: the stored byte and `act_idx` must match the captured values, not the scrambled ones.

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave #(
  parameter int BASE_ADDR = 'h40,
  parameter int STRIDE    = 2,
  parameter int ADDR_HI   = 7,
  parameter int ADDR_LO   = 1,
  parameter int NREG      = 8,
  parameter int DW        = 8,
  parameter int RW        = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_HI:ADDR_LO]   bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic                     bus_en,
  input  logic                     bus_wr,
  output logic                     bus_ack,
  output logic [RW-1:0]            bus_rdata,
  output logic                     bus_sel,
  output logic                     act_wr,
  output logic                     act_rd,
  output logic [$clog2(NREG)-1:0]  act_idx
);
  localparam int BW = ADDR_HI + 1;
  localparam int IW = $clog2(NREG);
  localparam logic [BW-1:0] BASE_V   = BASE_ADDR[BW-1:0];
  localparam logic [BW-1:0] SPAN_V   = BW'(NREG * STRIDE);
  localparam logic [BW-1:0] STRIDE_V = BW'(STRIDE);

  logic [BW-1:0] byte_addr, offset;
  logic          hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] regs [NREG];

  logic          en_d;
  logic          hit_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic          fall;

  assign byte_addr = {bus_addr, {ADDR_LO{1'b0}}};
  assign offset    = byte_addr - BASE_V;
  assign hit       = (offset < SPAN_V) && ((offset % STRIDE_V) == '0);
  assign idx       = IW'(offset / STRIDE_V);

  assign bus_sel   = bus_en && hit;
  assign bus_rdata = bus_sel ? {{(RW-DW){1'b0}}, regs[idx]} : '0;
  assign fall      = en_d && !bus_en;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      en_d    <= 1'b0;
      bus_ack <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      en_d    <= bus_en;
      bus_ack <= bus_sel;
      if (bus_en) begin
        hit_q  <= hit;
        idx_q  <= idx;
        data_q <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act_wr  <= 1'b0;
      act_rd  <= 1'b0;
      act_idx <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      act_wr <= fall && hit_q && bus_wr;
      act_rd <= fall && hit_q && !bus_wr;
      if (fall && hit_q) begin
        act_idx <= idx_q;
        if (bus_wr) regs[idx_q] <= data_q;
      end
    end
  end

  AST_SEL_NEEDS_EN:  assert property (@(posedge clk) disable iff (rst) bus_sel |-> bus_en);                       // R1
  AST_ACK_FOLLOWS:   assert property (@(posedge clk) disable iff (rst) bus_sel |=> bus_ack);                      // R3
  AST_ACK_DROPS:     assert property (@(posedge clk) disable iff (rst) !bus_en |=> !bus_ack);                     // R3
  AST_PULSE_EXCL:    assert property (@(posedge clk) disable iff (rst) !(act_wr && act_rd));                      // R6
  AST_PULSE_SINGLE:  assert property (@(posedge clk) disable iff (rst) (act_wr || act_rd) |=> !(act_wr || act_rd)); // R6
  AST_PULSE_AFTER_DROP: assert property (@(posedge clk) disable iff (rst) (act_wr || act_rd) |-> !$past(bus_en)); // R5
endmodule

// File: tb/strobe_reg_slave_tb.sv
module strobe_reg_slave_tb;
  localparam int BASE = 'h40;
  localparam int STR  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:1] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_ack, bus_sel, act_wr, act_rd;
  logic [15:0] bus_rdata;
  logic [2:0] act_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  strobe_reg_slave #(.BASE_ADDR(BASE), .STRIDE(STR), .ADDR_HI(7), .ADDR_LO(1)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_sel(bus_sel), .act_wr(act_wr), .act_rd(act_rd), .act_idx(act_idx)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input logic [6:0] a, input logic wr, input logic [7:0] d);
    int ba;
    int off;
    logic hit;
    logic [2:0] ix;
    ba  = int'(a) * 2;
    off = ba - BASE;
    hit = (off >= 0) && (off < 8*STR) && (off % STR == 0);
    ix  = hit ? 3'(off / STR) : 3'd0;
    @(negedge clk);
    bus_en = 1'b1; bus_addr = a; bus_wr = wr; bus_wdata = d;
    #1;
    chk("R1 sel", 16'(bus_sel), 16'(hit));
    chk("R4 rdata", bus_rdata, hit ? {8'h00, model[ix]} : 16'h0000);
    @(negedge clk);
    chk("R3 ack high", 16'(bus_ack), 16'(hit));
    chk("R2 act idle", {14'h0, act_wr, act_rd}, 16'h0);
    @(negedge clk);
    bus_en = 1'b0; bus_addr = a ^ 7'h55; bus_wdata = ~d;
    #1;
    chk("R1 sel low", 16'(bus_sel), 16'h0);
    @(negedge clk);
    chk("R3 ack low", 16'(bus_ack), 16'h0);
    chk("R6 act_wr", 16'(act_wr), 16'(hit && wr));
    chk("R6 act_rd", 16'(act_rd), 16'(hit && !wr));
    if (hit) chk("R6 act_idx", 16'(act_idx), 16'(ix));
    if (hit && wr) model[ix] = d;
    @(negedge clk);
    chk("R6 single pulse", {14'h0, act_wr, act_rd}, 16'h0);
    bus_wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    chk("R7 reset ack", 16'(bus_ack), 16'h0);
    chk("R7 reset pulses", {14'h0, act_wr, act_rd}, 16'h0);
    rst = 1'b0;
    // R7: all registers read zero after reset; R2/R4 for every address
    for (int a = 0; a < 128; a++) access(7'(a), 1'b0, 8'hA5);
    // R5: write every register with distinct patterns
    for (int i = 0; i < 8; i++) access(7'((BASE + i*STR) / 2), 1'b1, 8'(i*37 + 11));
    // R2: writes outside the window change nothing
    access(7'h00, 1'b1, 8'hFF);
    access(7'((BASE - 2) / 2), 1'b1, 8'hEE);
    access(7'((BASE + 8*STR) / 2), 1'b1, 8'hDD);
    access(7'h7F, 1'b1, 8'hCC);
    // R8: read sweep twice; reads must not alter contents
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 128; a++) access(7'(a), 1'b0, 8'h00);
    // R5: overwrite in reverse order, then verify
    for (int i = 7; i >= 0; i--) access(7'((BASE + i*STR) / 2), 1'b1, 8'(255 - i*19));
    for (int i = 0; i < 8; i++) access(7'((BASE + i*STR) / 2), 1'b0, 8'h00);
    // R7: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) access(7'((BASE + i*STR) / 2), 1'b0, 8'h00);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule